// File: doc/BRIEF.md
# Card Command Line Transmitter

This block puts one memory-card command onto a single serial command line. Software loads five bytes through a byte write port into a small transmit store: the command index byte goes in first, then the 32-bit argument, most significant byte first. It then arms the transfer by raising a start control and launches it by lowering that control again. The block builds a 48-bit frame from the stored bytes. It adds framing bits and a CRC7 that it computes itself, and shifts the frame out most significant bit first, one bit for each pulse of a bit-rate strobe supplied from outside.

From the moment the transfer is armed until its last bit has gone out, the block holds a lock flag, and byte writes are dropped so that a new command cannot corrupt the one in flight. When the frame is complete, an end-of-command flag rises and the lock drops. The flag can drive an interrupt request and is cleared by a read strobe. A second control, raised and then lowered, moves the write pointer back to the first slot so that a half-loaded command can be abandoned.

Top module: `cmd_line_tx`

## Requirements
- R1: After reset `cmd_line` is 1, `lock` is 0, `eoc` is 0 and `irq` is 0. `cmd_line` is 1 whenever no frame is being shifted.
- R2: Accepted writes fill slots 0 to 4 in order: slot 0 is the index byte and slots 1 to 4 are argument bits 31:24 down to 7:0. Writes made after the fifth are ignored.
- R3: The frame is 48 bits sent MSB first: bit 47 = 0, bit 46 = 1, bits 45:40 = index bits 5:0 (the top two bits of the index byte are dropped), bits 39:8 = argument, bits 7:1 = CRC7, bit 0 = 1. The first frame bit appears on `cmd_line` in the cycle after the start edge is sampled, and each `bit_tick` pulse advances the line by one bit.
- R4: The CRC7 uses polynomial x^7+x^3+1 with the register starting at zero. It covers frame bits 47:8. Index 0 with argument 0 gives the frame 48'h400000000095.
- R5: A transfer starts only when `start_ctl` is sampled low after having been sampled high while the block was idle. Holding `start_ctl` high leaves `cmd_line` at 1.
- R6: `lock` becomes 1 one cycle after `start_ctl` is sampled high while idle. While `lock` is 1, `wr_en` writes change neither the stored bytes nor the write pointer.
- R7: On the 48th `bit_tick` of a frame, in the same clock edge, the line returns to 1, `lock` clears, `eoc` sets and the write pointer returns to slot 0.
- R8: A `flag_rd` pulse clears `eoc`. A flag being set in the same cycle takes priority over the clear.
- R9: `irq` equals `eoc` AND `irq_en`.
- R10: When `ptr_rst_ctl` is sampled low after being sampled high while `lock` is 0, the write pointer returns to slot 0, and the next write lands in the index slot.
- R11: `bit_tick` pulses have no effect while no frame is in progress.
- R12: A start edge that arrives while a frame is being shifted is ignored, and the frame in progress goes out unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per card bit period |
| wr_en | input | 1 | Byte write strobe into the command store |
| wr_data | input | 8 | Byte to store |
| start_ctl | input | 1 | Arm when high, launch on the following low |
| ptr_rst_ctl | input | 1 | Write-pointer reset, acts on high then low |
| flag_rd | input | 1 | Read strobe that clears the end flag |
| irq_en | input | 1 | Interrupt enable for the end flag |
| cmd_line | output | 1 | Serial command line, idles high |
| lock | output | 1 | Write lock, high while a transfer is armed or running |
| eoc | output | 1 | End-of-command flag |
| irq | output | 1 | Interrupt request |

## Verification
Byte writes, pointer resets and the arming of the lock all take effect at the first clock edge that samples them, so the bench drives inputs on falling edges and reads the result on the next falling edge. The frame begins on the line one edge after `start_ctl` is sampled low. Each following bit appears one edge after a `bit_tick` is sampled. The bench therefore captures every bit on the falling edge just before it pulses the tick. `eoc`, the lock release and the pointer rewind all land on the edge that samples the 48th tick, so they are checked on the falling edge that follows the capture loop. `irq` is combinational from `eoc` and is checked in the same half-cycle as its enable.

// File: rtl/cmd_tx_pkg.sv
package cmd_tx_pkg;
  localparam int BYTE_W    = 8;
  localparam int CMD_BYTES = 5;
  localparam int ARG_W     = (CMD_BYTES - 1) * BYTE_W;
  localparam int IDX_W     = 6;
  localparam int CRC_W     = 7;
  localparam int BODY_W    = 2 + IDX_W + ARG_W;
  localparam int FRAME_W   = BODY_W + CRC_W + 1;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  // one serial step of the CRC7 shift register
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
    logic fb;
    logic [CRC_W-1:0] n;
    fb = c[CRC_W-1] ^ b;
    n  = {c[CRC_W-2:0], 1'b0};
    if (fb) n = n ^ CRC_POLY;
    return n;
  endfunction

  function automatic logic [CRC_W-1:0] crc7_body(input logic [BODY_W-1:0] m);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) c = crc7_step(c, m[i]);
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] make_frame(input logic [BYTE_W-1:0] idx,
                                                     input logic [ARG_W-1:0] arg);
    logic [BODY_W-1:0] body;
    body = {2'b01, idx[IDX_W-1:0], arg};
    return {body, crc7_body(body), 1'b1};
  endfunction
endpackage

// File: rtl/cmd_tx_fifo.sv
module cmd_tx_fifo
  import cmd_tx_pkg::*;
#(
  parameter int DEPTH = CMD_BYTES,
  parameter int W     = BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [W-1:0]       wr_data,
  input  logic               lock,
  input  logic               clr_ptr,
  output logic [DEPTH*W-1:0] bytes_out
);
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wptr_q;
  logic [W-1:0]     slot_q [DEPTH];
  logic             accept;

  assign accept = wr_en && !lock && (wptr_q < PTR_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wptr_q <= '0;
    else if (clr_ptr) wptr_q <= '0;
    else if (accept)  wptr_q <= wptr_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q[g] <= '0;
      else if (accept && wptr_q == PTR_W'(g))      slot_q[g] <= wr_data;
    end
    assign bytes_out[(DEPTH-1-g)*W +: W] = slot_q[g];
  end

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q <= PTR_W'(DEPTH));
  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !clr_ptr |=> $stable(wptr_q));
endmodule

// File: rtl/cmd_tx_shifter.sv
module cmd_tx_shifter
  import cmd_tx_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          tick,
  input  logic [FW-1:0] frame,
  output logic          busy,
  output logic          done,
  output logic          line
);
  localparam int CNT_W = $clog2(FW);

  logic [FW-1:0]    sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done = busy_q && tick && (cnt_q == CNT_W'(FW - 1));
  assign busy = busy_q;
  assign line = busy_q ? sh_q[FW-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '1;
    end else if (load && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= frame;
    end else if (done) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && tick) begin
      cnt_q  <= cnt_q + 1'b1;
      sh_q   <= {sh_q[FW-2:0], 1'b1};
    end
  end

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !line);
  // R3
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick && !done |=> $stable(line));
  // R11
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !load |=> !busy_q && line);
  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q && line);
endmodule

// File: rtl/cmd_tx_ctrl.sv
module cmd_tx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ctl,
  input  logic ptr_rst_ctl,
  input  logic flag_rd,
  input  logic irq_en,
  input  logic busy,
  input  logic done,
  output logic load_evt,
  output logic abort_evt,
  output logic lock,
  output logic eoc,
  output logic irq
);
  logic start_q, ptr_q, lock_q, eoc_q;

  assign load_evt  = start_q && !start_ctl && !busy && lock_q;
  assign abort_evt = ptr_q && !ptr_rst_ctl && !lock_q;
  assign lock      = lock_q;
  assign eoc       = eoc_q;
  assign irq       = eoc_q && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      ptr_q   <= 1'b0;
      lock_q  <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      start_q <= start_ctl;
      ptr_q   <= ptr_rst_ctl;
      if (done)                   lock_q <= 1'b0;
      else if (start_ctl && !busy) lock_q <= 1'b1;
      if (done)         eoc_q <= 1'b1;
      else if (flag_rd) eoc_q <= 1'b0;
    end
  end

  // R6
  busy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lock_q);
  // R7
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> eoc_q && !lock_q);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd && !done |=> !eoc_q);
endmodule

// File: rtl/cmd_line_tx.sv
module cmd_line_tx
  import cmd_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              start_ctl,
  input  logic              ptr_rst_ctl,
  input  logic              flag_rd,
  input  logic              irq_en,
  output logic              cmd_line,
  output logic              lock,
  output logic              eoc,
  output logic              irq
);
  logic [CMD_BYTES*BYTE_W-1:0] bytes_w;
  logic [FRAME_W-1:0]          frame_w;
  logic load_evt, abort_evt, done_evt, busy_w;

  assign frame_w = make_frame(bytes_w[ARG_W +: BYTE_W], bytes_w[ARG_W-1:0]);

  cmd_tx_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_ctl(start_ctl), .ptr_rst_ctl(ptr_rst_ctl),
    .flag_rd(flag_rd), .irq_en(irq_en), .busy(busy_w), .done(done_evt),
    .load_evt(load_evt), .abort_evt(abort_evt), .lock(lock), .eoc(eoc), .irq(irq)
  );

  cmd_tx_fifo #(.DEPTH(CMD_BYTES), .W(BYTE_W)) i_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .lock(lock),
    .clr_ptr(abort_evt || done_evt), .bytes_out(bytes_w)
  );

  cmd_tx_shifter #(.FW(FRAME_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .tick(bit_tick), .frame(frame_w),
    .busy(busy_w), .done(done_evt), .line(cmd_line)
  );
endmodule

// File: tb/test_cmd_line_tx.sv
`timescale 1ns/1ps
module test_cmd_line_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 0, wr_en = 0, start_ctl = 0, ptr_rst_ctl = 0, flag_rd = 0, irq_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic cmd_line, lock, eoc, irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmd_line_tx i_cmd_line_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
    .start_ctl(start_ctl), .ptr_rst_ctl(ptr_rst_ctl), .flag_rd(flag_rd), .irq_en(irq_en),
    .cmd_line(cmd_line), .lock(lock), .eoc(eoc), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // remainder of body*x^7 divided by x^7+x^3+1
  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] d;
    d = {m, 7'b0};
    for (int i = 46; i >= 7; i--) if (d[i]) d[i-:8] = d[i-:8] ^ 8'h89;
    return d[6:0];
  endfunction

  function automatic logic [47:0] ref_frame(input logic [7:0] idx, input logic [31:0] arg);
    logic [39:0] body;
    body = {2'b01, idx[5:0], arg};
    return {body, ref_crc(body), 1'b1};
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load_cmd(input logic [7:0] idx, input logic [31:0] arg);
    put(idx); put(arg[31:24]); put(arg[23:16]); put(arg[15:8]); put(arg[7:0]);
  endtask

  task automatic arm_and_go();
    @(negedge clk); start_ctl = 1;
    @(negedge clk); start_ctl = 0;
    chk(lock === 1'b1, "R6 lock after arm", {47'b0, lock}, 48'd1);
    @(negedge clk);
  endtask

  // captures 48 bits; optional disturbance mid-frame
  task automatic run_frame(input bit disturb, output logic [47:0] got);
    for (int k = 0; k < 48; k++) begin
      if (disturb && k == 20) begin
        put(8'hFF); put(8'hEE); put(8'hDD); put(8'hCC); put(8'hBB);
        @(negedge clk); start_ctl = 1;
        @(negedge clk); start_ctl = 0;
        @(negedge clk);
      end
      got[47-k] = cmd_line;
      bit_tick = 1;
      @(negedge clk); bit_tick = 0;
      @(negedge clk);
    end
    chk(cmd_line === 1'b1, "R1 idle after frame", {47'b0, cmd_line}, 48'd1);
    chk(eoc === 1'b1 && lock === 1'b0, "R7 end flag and unlock", {46'b0, eoc, lock}, 48'd2);
  endtask

  task automatic send_and_check(input logic [7:0] idx, input logic [31:0] arg, input string req);
    logic [47:0] got;
    load_cmd(idx, arg);
    arm_and_go();
    run_frame(0, got);
    chk(got === ref_frame(idx, arg), req, got, ref_frame(idx, arg));
  endtask

  initial begin
    logic [47:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_line === 1'b1, "R1 line", {47'b0, cmd_line}, 48'd1);
    chk(lock === 1'b0, "R1 lock", {47'b0, lock}, 48'd0);
    chk(eoc === 1'b0, "R1 eoc", {47'b0, eoc}, 48'd0);
    chk(irq === 1'b0, "R1 irq", {47'b0, irq}, 48'd0);

    // R4 known vector
    load_cmd(8'h40, 32'h0);
    arm_and_go();
    run_frame(0, got);
    chk(got === 48'h400000000095, "R4 known CRC frame", got, 48'h400000000095);

    // R9 / R8
    irq_en = 0; @(negedge clk);
    chk(irq === 1'b0, "R9 irq masked", {47'b0, irq}, 48'd0);
    irq_en = 1; #0.1;
    chk(irq === 1'b1, "R9 irq enabled", {47'b0, irq}, 48'd1);
    @(negedge clk); flag_rd = 1; @(negedge clk); flag_rd = 0;
    chk(eoc === 1'b0 && irq === 1'b0, "R8 read clears eoc", {46'b0, eoc, irq}, 48'd0);

    // R10 abort partial load
    put(8'h11); put(8'h22); put(8'h33);
    @(negedge clk); ptr_rst_ctl = 1; @(negedge clk); ptr_rst_ctl = 0;
    send_and_check(8'h51, 32'h1234_5678, "R10 frame after pointer reset");

    // R2 overflow writes ignored
    load_cmd(8'h48, 32'h0000_01AA);
    put(8'h99); put(8'h77);
    arm_and_go();
    run_frame(0, got);
    chk(got === ref_frame(8'h48, 32'h1AA), "R2 extra writes ignored", got, ref_frame(8'h48, 32'h1AA));

    // R5 holding start high does not launch
    load_cmd(8'h4D, 32'hDEAD_BEEF);
    @(negedge clk); start_ctl = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bit_tick = 1; @(negedge clk); bit_tick = 0;
    end
    chk(cmd_line === 1'b1, "R5 held start keeps line high", {47'b0, cmd_line}, 48'd1);
    chk(lock === 1'b1, "R6 lock while armed", {47'b0, lock}, 48'd1);
    @(negedge clk); start_ctl = 0;
    @(negedge clk);
    // R6 / R12 writes and a start edge during the frame are ignored
    run_frame(1, got);
    chk(got === ref_frame(8'h4D, 32'hDEAD_BEEF), "R12 frame unchanged by mid-frame start",
        got, ref_frame(8'h4D, 32'hDEAD_BEEF));
    arm_and_go();
    run_frame(0, got);
    chk(got === ref_frame(8'h4D, 32'hDEAD_BEEF), "R6 locked writes did not reach store",
        got, ref_frame(8'h4D, 32'hDEAD_BEEF));

    // R11 idle ticks
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); bit_tick = 1; @(negedge clk); bit_tick = 0;
    end
    chk(cmd_line === 1'b1 && lock === 1'b0, "R11 idle ticks no effect", {46'b0, cmd_line, lock}, 48'd2);

    // R3 / R4 sweep over every index with varied arguments
    for (int n = 0; n < 64; n++) begin
      logic [31:0] a;
      a = (32'(n) + 32'd1) * 32'h9E37_79B9;
      send_and_check({n[1:0], 6'(n)}, a, "R3 R4 sweep frame");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule